// File: doc/BRIEF.md
# Multi-Cycle Load/Store/Branch Processor Core

This block is a small, non-pipelined 32-bit processor core. It runs a subset of a classic load/store instruction set: register-to-register arithmetic and logic, word load, word store and branch-on-equal. Every instruction passes through a short series of clock steps under a finite-state controller, and a single ALU is time-shared between the steps. It computes the next sequential PC, a speculative branch target, effective addresses and arithmetic results. The architectural state is the PC, an instruction register, two operand latches, an ALU result latch, a memory data latch and a 32-entry register file.

Instruction memory and data memory are separate arrays inside the core, so a fetch and a data access never contend. Both arrays are filled through a valid/ready program-load stream. A word offered with `prog_valid` is written only in a cycle where `prog_ready` is high, and `prog_ready` is high only while the core is held in reset. While the core runs, a word that is offered stays pending and writes nothing. The word it holds may change freely, because it is never taken. A debug port shows the PC and reads any register without any effect on execution.

Each instruction uses a fixed number of steps: 4 for arithmetic, 5 for a load, 4 for a store and 3 for a branch. An unrecognised encoding uses 2 steps and has no effect beyond the fetch.

Top module: `mc_core`

## Requirements
- R1: While reset is high, the PC is 0, every register reads 0 and the controller waits in its fetch step. Every instruction's first step loads the instruction register from instruction word PC[7:2] and adds 4 to the PC.
- R2: The second step latches the registers selected by bits 25:21 (rs) and 20:16 (rt). It also forms the branch candidate: the incremented PC plus the sign-extended bits 15:0 shifted left by two.
- R3: Opcode bits 31:26 = 0 selects an arithmetic operation by bits 5:0: 0x20 add, 0x22 sub (rs minus rt), 0x24 and, 0x25 or. The result is written to the register at bits 15:11 at the end of step 4, and the next fetch follows.
- R4: Opcode 0x23 (load) reads the data word at rs + sign-extended imm in step 4 and writes it to register rt in step 5.
- R5: Opcode 0x04 (branch) ends after step 3. If rs equals rt, the PC becomes the step-2 candidate. Otherwise the PC stays at the incremented value.
- R6: Opcode 0x2B (store) writes the value of rt to the data word at rs + sign-extended imm in step 4, and the instruction ends there.
- R7: Register 0 always reads as zero, and any write aimed at it is dropped.
- R8: Any other opcode, or an opcode-0 word whose bits 5:0 are not in the supported set, goes back to fetch after step 2. It changes no register and no data word, and leaves the PC at the incremented value.
- R9: A program-load word is written only when `prog_valid` and `prog_ready` are both high. `prog_ready` equals reset. `prog_to_dmem` = 1 targets data memory and 0 targets instruction memory, at word index `prog_addr`.
- R10: `dbg_pc` shows the PC. `dbg_rdata` combinationally shows the register selected by `dbg_raddr`.
- R11: Function 0x2A (set-less-than) writes 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R12: Data addresses use bits [7:2] only (64 words). Higher bits and the two low bits are ignored, so addresses alias modulo 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also opens program loading |
| prog_valid | input | 1 | A program-load word is offered |
| prog_ready | output | 1 | A program-load word can be taken this cycle |
| prog_to_dmem | input | 1 | 1 selects data memory, 0 instruction memory |
| prog_addr | input | 6 | Word index for the load |
| prog_data | input | 32 | Word to load |
| dbg_raddr | input | 5 | Register index to observe |
| dbg_rdata | output | 32 | Value of the observed register |
| dbg_pc | output | 32 | Current PC |

## Verification
The hardest situations to reach from the ports are instruction sequences that combine several corner cases. Examples are a taken backward branch that lands on a load, a load that reads back a word just written through an aliased address, and a write aimed at register 0 in the middle of these. Random programs draw their register indices from a small set, so branch operands are often equal and addresses often alias. A directed program forces the aliased store/load, the backward wrap and the signed comparison. During one run a program-load word is offered the whole time, to show that it cannot reach memory while the core runs.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_ALU    = 6'h00;
  localparam logic [5:0] OPC_LOAD   = 6'h23;
  localparam logic [5:0] OPC_STORE  = 6'h2B;
  localparam logic [5:0] OPC_BRANCH = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {CL_ALU, CL_LOAD, CL_STORE, CL_BRANCH} iclass_e;
  typedef enum logic [0:0] {SA_PC, SA_REGA} srca_e;
  typedef enum logic [1:0] {SB_REGB, SB_FOUR, SB_IMM, SB_BROFF} srcb_e;

  typedef struct packed {
    logic    known;
    iclass_e cls;
    alu_op_e fn;
  } idec_t;

  function automatic idec_t decode_word(input logic [5:0] opc, input logic [5:0] fn);
    idec_t d;
    d.known = 1'b1;
    d.cls   = CL_ALU;
    d.fn    = ALU_ADD;
    case (opc)
      OPC_ALU: begin
        case (fn)
          FN_ADD:  d.fn = ALU_ADD;
          FN_SUB:  d.fn = ALU_SUB;
          FN_AND:  d.fn = ALU_AND;
          FN_OR:   d.fn = ALU_OR;
          FN_SLT:  d.fn = ALU_SLT;
          default: d.known = 1'b0;
        endcase
      end
      OPC_LOAD:   d.cls = CL_LOAD;
      OPC_STORE:  d.cls = CL_STORE;
      OPC_BRANCH: d.cls = CL_BRANCH;
      default:    d.known = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  parameter int NRD  = 3,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end
  endgenerate
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  input  logic       alu_zero,
  output step_e      state,
  output idec_t      dec,
  output srca_e      src_a,
  output srcb_e      src_b,
  output alu_op_e    alu_op,
  output logic       ir_we,
  output logic       pc_we,
  output logic       pc_from_aluout,
  output logic       ab_we,
  output logic       aluout_we,
  output logic       mdr_we,
  output logic       rf_we,
  output logic       rf_dst_rd,
  output logic       dmem_we
);
  step_e nxt;

  assign dec = decode_word(opc, fn);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt            = state;
    src_a          = SA_PC;
    src_b          = SB_FOUR;
    alu_op         = ALU_ADD;
    ir_we          = 1'b0;
    pc_we          = 1'b0;
    pc_from_aluout = 1'b0;
    ab_we          = 1'b0;
    aluout_we      = 1'b0;
    mdr_we         = 1'b0;
    rf_we          = 1'b0;
    rf_dst_rd      = 1'b0;
    dmem_we        = 1'b0;
    case (state)
      ST_FETCH: begin
        ir_we = 1'b1;
        pc_we = 1'b1;
        nxt   = ST_DECODE;
      end
      ST_DECODE: begin
        src_b = SB_BROFF;
        if (dec.known) begin
          ab_we     = 1'b1;
          aluout_we = 1'b1;
          nxt       = ST_EXEC;
        end else begin
          nxt = ST_FETCH;
        end
      end
      ST_EXEC: begin
        src_a = SA_REGA;
        case (dec.cls)
          CL_BRANCH: begin
            src_b          = SB_REGB;
            alu_op         = ALU_SUB;
            pc_we          = alu_zero;
            pc_from_aluout = 1'b1;
            nxt            = ST_FETCH;
          end
          CL_ALU: begin
            src_b     = SB_REGB;
            alu_op    = dec.fn;
            aluout_we = 1'b1;
            nxt       = ST_MEM;
          end
          default: begin
            src_b     = SB_IMM;
            aluout_we = 1'b1;
            nxt       = ST_MEM;
          end
        endcase
      end
      ST_MEM: begin
        case (dec.cls)
          CL_LOAD: begin
            mdr_we = 1'b1;
            nxt    = ST_WB;
          end
          CL_STORE: begin
            dmem_we = 1'b1;
            nxt     = ST_FETCH;
          end
          default: begin
            rf_we     = 1'b1;
            rf_dst_rd = 1'b1;
            nxt       = ST_FETCH;
          end
        endcase
      end
      ST_WB: begin
        rf_we = 1'b1;
        nxt   = ST_FETCH;
      end
      default: nxt = ST_FETCH;
    endcase
  end

  // R8: an unsupported encoding goes straight back to fetch
  p_unknown_to_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !dec.known) |=> (state == ST_FETCH));

  // R4: the fifth step only ever follows the memory step
  p_wb_after_mem_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> ($past(state) == ST_MEM));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  parameter int IAW        = $clog2(IMEM_DEPTH),
  parameter int DAW        = $clog2(DMEM_DEPTH),
  parameter int PAW        = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_valid,
  output logic            prog_ready,
  input  logic            prog_to_dmem,
  input  logic [PAW-1:0]  prog_addr,
  input  logic [XLEN-1:0] prog_data,
  input  logic [RIDX-1:0] dbg_raddr,
  output logic [XLEN-1:0] dbg_rdata,
  output logic [XLEN-1:0] dbg_pc
);
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;

  step_e   state;
  idec_t   dec;
  srca_e   src_a;
  srcb_e   src_b;
  alu_op_e alu_op;
  logic    ir_we, pc_we, pc_from_aluout, ab_we, aluout_we, mdr_we;
  logic    rf_we, rf_dst_rd, dmem_core_we;

  logic [XLEN-1:0] alu_a, alu_b, alu_y, sext_imm;
  logic            alu_zero;

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opc(ir_q[31:26]), .fn(ir_q[5:0]), .alu_zero(alu_zero),
    .state(state), .dec(dec), .src_a(src_a), .src_b(src_b), .alu_op(alu_op),
    .ir_we(ir_we), .pc_we(pc_we), .pc_from_aluout(pc_from_aluout), .ab_we(ab_we),
    .aluout_we(aluout_we), .mdr_we(mdr_we), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
    .dmem_we(dmem_core_we)
  );

  assign sext_imm = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_a    = (src_a == SA_PC) ? pc_q : a_q;

  always_comb begin
    case (src_b)
      SB_REGB:  alu_b = b_q;
      SB_FOUR:  alu_b = XLEN'(4);
      SB_IMM:   alu_b = sext_imm;
      default:  alu_b = {sext_imm[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a(alu_a), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero)
  );

  // register file: port 0 = rs, port 1 = rt, port 2 = debug
  logic [2:0][RIDX-1:0] rf_ra;
  logic [2:0][XLEN-1:0] rf_rd;
  logic [RIDX-1:0]      rf_wa;
  logic [XLEN-1:0]      rf_wd;

  assign rf_ra = {dbg_raddr, ir_q[20:16], ir_q[25:21]};
  assign rf_wa = rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = rf_dst_rd ? aluout_q : mdr_q;

  mc_regfile #(.W(XLEN), .NREG(NREG), .NRD(3), .AW(RIDX)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
    .raddr(rf_ra), .rdata(rf_rd)
  );

  // memories and the program-load stream
  logic            load_take, imem_we, dmem_load_we, dmem_we;
  logic [XLEN-1:0] imem_q, dmem_q, dmem_wd;
  logic [DAW-1:0]  dmem_wa;

  assign prog_ready   = rst;
  assign load_take    = prog_valid & prog_ready;
  assign imem_we      = load_take & ~prog_to_dmem;
  assign dmem_load_we = load_take & prog_to_dmem;
  assign dmem_we      = dmem_core_we | dmem_load_we;
  assign dmem_wa      = dmem_load_we ? prog_addr[DAW-1:0] : aluout_q[2 +: DAW];
  assign dmem_wd      = dmem_load_we ? prog_data : b_q;

  mc_mem #(.W(XLEN), .DEPTH(IMEM_DEPTH), .AW(IAW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(prog_addr[IAW-1:0]), .wdata(prog_data),
    .raddr(pc_q[2 +: IAW]), .rdata(imem_q)
  );

  mc_mem #(.W(XLEN), .DEPTH(DMEM_DEPTH), .AW(DAW)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_wa), .wdata(dmem_wd),
    .raddr(aluout_q[2 +: DAW]), .rdata(dmem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (ir_we)     ir_q     <= imem_q;
      if (pc_we)     pc_q     <= pc_from_aluout ? aluout_q : alu_y;
      if (ab_we) begin
        a_q <= rf_rd[0];
        b_q <= rf_rd[1];
      end
      if (aluout_we) aluout_q <= alu_y;
      if (mdr_we)    mdr_q    <= dmem_q;
    end
  end

  assign dbg_pc    = pc_q;
  assign dbg_rdata = rf_rd[2];

  // R1: fetch always advances the PC by one word
  p_fetch_advance_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R5: equal operands commit the speculative target
  p_branch_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && dec.cls == CL_BRANCH && a_q == b_q) |=> (pc_q == $past(aluout_q)));

  // R5: unequal operands leave the PC alone
  p_branch_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && dec.cls == CL_BRANCH && a_q != b_q) |=> $stable(pc_q));

  // R6: a data write by the core only follows the address step
  p_store_after_exec_r6: assert property (@(posedge clk) disable iff (rst)
    dmem_core_we |-> ($past(state) == ST_EXEC));
endmodule

// File: tb/sim_mc_core.sv
`timescale 1ns/1ps
module sim_mc_core;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_valid = 1'b0;
  logic        prog_to_dmem = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [4:0]  dbg_raddr = '0;
  logic        prog_ready;
  logic [31:0] dbg_rdata, dbg_pc;

  always #2 clk = ~clk;

  mc_core u0 (
    .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_to_dmem(prog_to_dmem), .prog_addr(prog_addr), .prog_data(prog_data),
    .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata), .dbg_pc(dbg_pc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_rf [32];
  logic [31:0] m_dm [DEPTH];
  logic [31:0] m_im [DEPTH];
  logic [31:0] m_pc;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  // reference model: executes one instruction, returns its step count
  function automatic int ref_step(output string tag, output int dst);
    logic [31:0] ir, a, b, simm, addr, res;
    int rs, rt, rd;
    ir   = m_im[m_pc[7:2]];
    m_pc = m_pc + 32'd4;
    rs   = int'(ir[25:21]);
    rt   = int'(ir[20:16]);
    rd   = int'(ir[15:11]);
    a    = m_rf[rs];
    b    = m_rf[rt];
    simm = {{16{ir[15]}}, ir[15:0]};
    addr = a + simm;
    case (ir[31:26])
      6'h00: begin
        case (ir[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin
            tag = "R8";
            dst = rs;
            return 2;
          end
        endcase
        if (rd != 0) m_rf[rd] = res;
        dst = rd;
        tag = (ir[5:0] == 6'h2A) ? "R11" : ((rd == 0) ? "R7" : "R3");
        return 4;
      end
      6'h23: begin
        if (rt != 0) m_rf[rt] = m_dm[addr[7:2]];
        dst = rt;
        tag = (rt == 0) ? "R7" : ((addr[31:8] != 0) ? "R12" : "R4");
        return 5;
      end
      6'h2B: begin
        m_dm[addr[7:2]] = b;
        dst = rt;
        tag = "R6";
        return 4;
      end
      6'h04: begin
        if (a == b) m_pc = m_pc + {simm[29:0], 2'b00};
        dst = rs;
        tag = "R5";
        return 3;
      end
      default: begin
        dst = rt;
        tag = "R8";
        return 2;
      end
    endcase
  endfunction

  task automatic load_all();
    rst = 1'b1;
    @(negedge clk);
    check("R9", "ready in reset", {31'd0, prog_ready}, 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      prog_valid = 1'b1; prog_to_dmem = 1'b0; prog_addr = 6'(i); prog_data = m_im[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      prog_valid = 1'b1; prog_to_dmem = 1'b1; prog_addr = 6'(i); prog_data = m_dm[i];
    end
    @(negedge clk);
    prog_valid = 1'b0;
    check("R1", "pc in reset", dbg_pc, 32'd0);
    dbg_raddr = 5'd3;
    #0.1;
    check("R10", "reg3 in reset", dbg_rdata, 32'd0);
  endtask

  task automatic run_prog(input int n_instr, input bit offer_junk, input logic [31:0] junk);
    string tag;
    int dst, n;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_pc = '0;
    @(negedge clk);
    rst = 1'b0;
    if (offer_junk) begin
      prog_valid = 1'b1; prog_to_dmem = 1'b0; prog_addr = 6'd10; prog_data = junk;
    end
    #0.1;
    check("R9", "ready while running", {31'd0, prog_ready}, 32'd0);
    for (int k = 0; k < n_instr; k++) begin
      n = ref_step(tag, dst);
      repeat (n) @(posedge clk);
      @(negedge clk);
      check(tag, "pc", dbg_pc, m_pc);
      dbg_raddr = 5'(dst);
      #0.1;
      check(tag, "reg", dbg_rdata, m_rf[dst]);
    end
    @(negedge clk);
    rst = 1'b1;
    prog_valid = 1'b0;
  endtask

  task automatic gen_random();
    int r;
    for (int i = 0; i < DEPTH; i++) begin
      m_dm[i] = $urandom();
      r = $urandom_range(0, 99);
      if (r < 30) begin
        case ($urandom_range(0, 5))
          0: m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 7), 6'h20);
          1: m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 7), 6'h22);
          2: m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 7), 6'h24);
          3: m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 7), 6'h25);
          4: m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 7), 6'h2A);
          default: m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 7), 6'h21);
        endcase
      end else if (r < 55) m_im[i] = enc_i(6'h23, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 65535));
      else if (r < 70)     m_im[i] = enc_i(6'h2B, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 65535));
      else if (r < 85)     m_im[i] = enc_i(6'h04, $urandom_range(0, 7), $urandom_range(0, 7), int'($urandom_range(0, 12)) - 6);
      else if (r < 92)     m_im[i] = enc_i(6'h08, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 65535));
      else                 m_im[i] = enc_r($urandom_range(0, 7), $urandom_range(0, 7), 0, 6'h20);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // directed program: signed compare, r0 write, aliased store/load, branches, unknown word
    for (int i = 0; i < DEPTH; i++) begin
      m_im[i] = 32'h0;
      m_dm[i] = 32'(i * 3);
    end
    m_dm[0] = 32'd5;
    m_dm[1] = 32'hFFFF_FFFD;
    m_im[0]  = enc_i(6'h23, 0, 1, 0);      // R4 load r1
    m_im[1]  = enc_i(6'h23, 0, 2, 4);      // R4 load r2 = -3
    m_im[2]  = enc_r(2, 1, 3, 6'h2A);      // R11 -3 < 5 -> 1
    m_im[3]  = enc_r(1, 2, 4, 6'h22);      // R3 5 - (-3) = 8
    m_im[4]  = enc_r(1, 1, 0, 6'h20);      // R7 write to r0 dropped
    m_im[5]  = enc_i(6'h2B, 0, 4, 256);    // R12 store aliases word 0
    m_im[6]  = enc_i(6'h23, 0, 5, 0);      // R12 reads 8 back
    m_im[7]  = enc_i(6'h04, 3, 3, 1);      // R5 taken, skips next
    m_im[8]  = enc_r(1, 1, 6, 6'h25);
    m_im[9]  = 32'hFC00_0000;              // R8 unknown opcode
    m_im[10] = enc_r(1, 4, 6, 6'h24);      // R3 5 & 8 = 0
    m_im[11] = enc_i(6'h04, 1, 2, -12);    // R5 not taken
    m_im[12] = enc_r(1, 2, 7, 6'h2A);      // R11 5 < -3 -> 0
    m_im[13] = enc_i(6'h23, 0, 0, 4);      // R7 load into r0 dropped
    m_im[14] = enc_r(1, 2, 8, 6'h27);      // R8 unsupported function
    m_im[15] = enc_i(6'h04, 0, 0, -16);    // R5 backward to 0
    load_all();
    run_prog(40, 1'b1, enc_r(1, 1, 6, 6'h20));

    for (int p = 0; p < 16; p++) begin
      gen_random();
      load_all();
      run_prog(120, p[0], $urandom());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule